// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor whose instructions take several clock cycles, each cycle doing one small piece of work on a shared datapath. It is a Moore state machine: its sixteen control outputs depend only on the current state, and the instruction opcode only affects which state comes next. Every instruction starts with the same two states, fetch and decode. After decode, the machine goes down a path chosen by the opcode: loads, stores, register-to-register operations, equal-compare branches or jumps. When the path ends, the machine returns to fetch. A load takes five cycles, a store or register operation takes four, and a branch or jump takes three.

The datapath uses the outputs to control memory access, writes to the instruction register and program counter, the program-counter source select, the two ALU operand selects, the ALU operation class, the register-file destination select, the write-back source select and the register write strobe. A build-time parameter swaps the sequencing logic for a 1024-entry lookup table. The table is addressed by the 4-bit state and the 6-bit opcode, and each entry holds 16 control bits and 4 next-state bits. This gives a second form of the same machine that can be checked for equivalence against the direct form.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the machine in the fetch state, including when it is partway through an instruction. While reset is held, the outputs show the fetch pattern.
- R2: In fetch, the outputs are `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `iord`=0, `alu_a_sel`=0, `alu_b_sel`=01 (constant four), `alu_op`=00 (add) and `pc_src`=00 (ALU result), with every other output 0. Fetch is always followed by decode.
- R3: In decode, the outputs are `alu_a_sel`=0, `alu_b_sel`=11 (shifted immediate) and `alu_op`=00, with every other output 0.
- R4: Opcode 0x23 (load) goes through address calculation, memory read and write-back, then returns to fetch, for 5 cycles in all. Address calculation drives `alu_a_sel`=1, `alu_b_sel`=10 (sign-extended immediate) and `alu_op`=00. Memory read drives `mem_rd`=1 and `iord`=1. Write-back drives `reg_wr`=1, `mem_to_reg`=1 and `reg_dst`=0.
- R5: Opcode 0x2B (store) goes through address calculation, then a memory write with `mem_wr`=1 and `iord`=1, then returns to fetch, for 4 cycles in all.
- R6: Opcode 0x00 (register operation) goes through an execute state with `alu_a_sel`=1, `alu_b_sel`=00 and `alu_op`=10 (function field), then a completion state with `reg_wr`=1, `reg_dst`=1 and `mem_to_reg`=0, then returns to fetch, for 4 cycles in all.
- R7: Opcode 0x04 (branch if equal) goes through one state with `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=01 (saved target), then returns to fetch, for 3 cycles in all.
- R8: Opcode 0x02 (jump) goes through one state with `pc_wr`=1 and `pc_src`=10 (jump target), then returns to fetch, for 3 cycles in all.
- R9: The opcode is used only during decode. Its value in any other state has no effect on the sequence or the outputs.
- R10: Any other opcode in decode sends the machine straight back to fetch, so the instruction takes 2 cycles.
- R11: `mem_rd` and `mem_wr` are never both high, and `pc_wr` and `pc_wr_cond` are never both high.
- R12: With `TABLE_MODE`=1, the outputs match those of the direct form, cycle for cycle, for any sequence of opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| iord | output | 1 | Memory address select: 0 program counter, 1 ALU output register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write if the ALU result is zero |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 saved target, 10 jump target |
| alu_a_sel | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 four, 10 immediate, 11 immediate shifted by two |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| reg_dst | output | 1 | Destination register select: 0 rt field, 1 rd field |
| mem_to_reg | output | 1 | Write-back source: 0 ALU output, 1 memory data |
| reg_wr | output | 1 | Register file write strobe |

## Verification
Each instruction class is sent through the machine with its own directed opcode. The class fixes the length of the state path and the pattern of outputs in each state, so a wrong branch from decode or a wrong or missing state shows up as a mismatch on the 16-bit word or as a fetch that starts too early or too late. Random instruction streams mix all five classes with illegal opcodes. Random junk is placed on the opcode in every cycle except decode, which separates a machine that samples the opcode only in decode from one that reads it in later states. A second copy of the machine, built in table form, is compared with the first in every cycle. Reset is also applied partway through a load to confirm that it cuts the instruction short.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OPC_W  = 6;
  localparam int ST_W   = 4;
  localparam int CTRL_W = 16;
  localparam int ADDR_W = ST_W + OPC_W;
  localparam int WORD_W = CTRL_W + ST_W;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OP_JUMP  = 6'h02;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

  localparam logic [1:0] BSEL_REG   = 2'b00;
  localparam logic [1:0] BSEL_FOUR  = 2'b01;
  localparam logic [1:0] BSEL_IMM   = 2'b10;
  localparam logic [1:0] BSEL_SHIMM = 2'b11;

  localparam logic [1:0] AOP_ADD  = 2'b00;
  localparam logic [1:0] AOP_SUB  = 2'b01;
  localparam logic [1:0] AOP_FUNC = 2'b10;

  localparam logic [1:0] PSRC_ALU    = 2'b00;
  localparam logic [1:0] PSRC_TARGET = 2'b01;
  localparam logic [1:0] PSRC_JUMP   = 2'b10;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MADDR  = 4'd2,
    S_MREAD  = 4'd3,
    S_LDWB   = 4'd4,
    S_MWRITE = 4'd5,
    S_REXEC  = 4'd6,
    S_RDONE  = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9
  } state_e;

  typedef struct packed {
    logic       iord;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic [1:0] pc_src;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       reg_wr;
  } ctrl_t;

  // Moore output pattern of one state; unlisted signals stay zero.
  function automatic ctrl_t ctrl_of(state_e st);
    ctrl_t c;
    c = '0;
    case (st)
      S_FETCH: begin
        c.mem_rd    = 1'b1;
        c.ir_wr     = 1'b1;
        c.pc_wr     = 1'b1;
        c.alu_b_sel = BSEL_FOUR;
        c.alu_op    = AOP_ADD;
        c.pc_src    = PSRC_ALU;
      end
      S_DECODE: begin
        c.alu_b_sel = BSEL_SHIMM;
        c.alu_op    = AOP_ADD;
      end
      S_MADDR: begin
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = BSEL_IMM;
        c.alu_op    = AOP_ADD;
      end
      S_MREAD: begin
        c.mem_rd = 1'b1;
        c.iord   = 1'b1;
      end
      S_LDWB: begin
        c.reg_wr     = 1'b1;
        c.mem_to_reg = 1'b1;
        c.reg_dst    = 1'b0;
      end
      S_MWRITE: begin
        c.mem_wr = 1'b1;
        c.iord   = 1'b1;
      end
      S_REXEC: begin
        c.alu_a_sel = 1'b1;
        c.alu_b_sel = BSEL_REG;
        c.alu_op    = AOP_FUNC;
      end
      S_RDONE: begin
        c.reg_wr  = 1'b1;
        c.reg_dst = 1'b1;
      end
      S_BRANCH: begin
        c.alu_a_sel  = 1'b1;
        c.alu_b_sel  = BSEL_REG;
        c.alu_op     = AOP_SUB;
        c.pc_wr_cond = 1'b1;
        c.pc_src     = PSRC_TARGET;
      end
      S_JUMP: begin
        c.pc_wr  = 1'b1;
        c.pc_src = PSRC_JUMP;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  // Opcode only matters in decode and in the load/store split.
  function automatic state_e next_of(state_e st, logic [OPC_W-1:0] op);
    state_e n;
    case (st)
      S_FETCH:  n = S_DECODE;
      S_DECODE: begin
        case (op)
          OP_LOAD, OP_STORE: n = S_MADDR;
          OP_RTYPE:          n = S_REXEC;
          OP_BEQ:            n = S_BRANCH;
          OP_JUMP:           n = S_JUMP;
          default:           n = S_FETCH;
        endcase
      end
      S_MADDR:  n = S_FETCH;
      S_MREAD:  n = S_LDWB;
      S_REXEC:  n = S_RDONE;
      default:  n = S_FETCH;
    endcase
    return n;
  endfunction

  // Table word for a {state, opcode} address: {next state, controls}.
  function automatic logic [WORD_W-1:0] table_word(logic [ADDR_W-1:0] addr);
    state_e st;
    st = state_e'(addr[ADDR_W-1:OPC_W]);
    return {next_of(st, addr[OPC_W-1:0]), ctrl_of(st)};
  endfunction

endpackage

// File: rtl/mcc_state_reg.sv
module mcc_state_reg
  import mcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_e nxt,
  output state_e cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= S_FETCH;
    else     cur <= nxt;
  end

endmodule

// File: rtl/mcc_direct_logic.sv
module mcc_direct_logic
  import mcc_pkg::*;
(
  input  state_e           cur,
  input  logic [OPC_W-1:0] opcode,
  input  logic             mem_op_store,
  output state_e           nxt,
  output ctrl_t            ctrl
);

  always_comb begin
    nxt = next_of(cur, opcode);
    // The address state splits on the opcode kept from decode.
    if (cur == S_MADDR) nxt = mem_op_store ? S_MWRITE : S_MREAD;
    ctrl = ctrl_of(cur);
  end

endmodule

// File: rtl/mcc_rom_logic.sv
module mcc_rom_logic
  import mcc_pkg::*;
(
  input  state_e           cur,
  input  logic [OPC_W-1:0] opcode,
  input  logic             mem_op_store,
  output state_e           nxt,
  output ctrl_t            ctrl
);

  logic [WORD_W-1:0] rom [DEPTH];
  logic [WORD_W-1:0] word;
  state_e            rom_nxt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = table_word(ADDR_W'(i));
  end

  assign word    = rom[{cur, opcode}];
  assign rom_nxt = state_e'(word[WORD_W-1:CTRL_W]);
  assign ctrl    = ctrl_t'(word[CTRL_W-1:0]);

  always_comb begin
    nxt = rom_nxt;
    if (cur == S_MADDR) nxt = mem_op_store ? S_MWRITE : S_MREAD;
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter bit TABLE_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             iord,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_wr,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic [1:0]       pc_src,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic             reg_dst,
  output logic             mem_to_reg,
  output logic             reg_wr
);

  state_e cur, nxt;
  ctrl_t  ctrl;
  logic   mem_op_store;

  // Named state events for the properties below.
  logic in_fetch, in_decode, in_mread, in_rexec, in_rdone, in_branch, in_jump, in_ldwb;
  assign in_fetch  = (cur == S_FETCH);
  assign in_decode = (cur == S_DECODE);
  assign in_mread  = (cur == S_MREAD);
  assign in_ldwb   = (cur == S_LDWB);
  assign in_rexec  = (cur == S_REXEC);
  assign in_rdone  = (cur == S_RDONE);
  assign in_branch = (cur == S_BRANCH);
  assign in_jump   = (cur == S_JUMP);

  // Load/store flavour is latched while the opcode is valid in decode,
  // so later opcode values cannot steer the memory path.
  always_ff @(posedge clk) begin
    if (rst)            mem_op_store <= 1'b0;
    else if (in_decode) mem_op_store <= (opcode == OP_STORE);
  end

  mcc_state_reg u_state (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .cur (cur)
  );

  if (TABLE_MODE) begin : g_table
    mcc_rom_logic u_logic (
      .cur          (cur),
      .opcode       (opcode),
      .mem_op_store (mem_op_store),
      .nxt          (nxt),
      .ctrl         (ctrl)
    );
  end else begin : g_direct
    mcc_direct_logic u_logic (
      .cur          (cur),
      .opcode       (opcode),
      .mem_op_store (mem_op_store),
      .nxt          (nxt),
      .ctrl         (ctrl)
    );
  end

  assign iord       = ctrl.iord;
  assign mem_rd     = ctrl.mem_rd;
  assign mem_wr     = ctrl.mem_wr;
  assign ir_wr      = ctrl.ir_wr;
  assign pc_wr      = ctrl.pc_wr;
  assign pc_wr_cond = ctrl.pc_wr_cond;
  assign pc_src     = ctrl.pc_src;
  assign alu_a_sel  = ctrl.alu_a_sel;
  assign alu_b_sel  = ctrl.alu_b_sel;
  assign alu_op     = ctrl.alu_op;
  assign reg_dst    = ctrl.reg_dst;
  assign mem_to_reg = ctrl.mem_to_reg;
  assign reg_wr     = ctrl.reg_wr;

  p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
    in_fetch |=> in_decode);

  p_ir_single_r2: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> !ir_wr);

  p_read_then_wb_r4: assert property (@(posedge clk) disable iff (rst)
    in_mread |=> (reg_wr && mem_to_reg));

  p_wb_returns_r4: assert property (@(posedge clk) disable iff (rst)
    in_ldwb |=> in_fetch);

  p_exec_then_done_r6: assert property (@(posedge clk) disable iff (rst)
    in_rexec |=> (in_rdone && reg_wr && reg_dst));

  p_done_returns_r6: assert property (@(posedge clk) disable iff (rst)
    in_rdone |=> in_fetch);

  p_branch_returns_r7: assert property (@(posedge clk) disable iff (rst)
    in_branch |=> in_fetch);

  p_jump_returns_r8: assert property (@(posedge clk) disable iff (rst)
    in_jump |=> in_fetch);

  p_mem_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_pc_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(pc_wr && pc_wr_cond));

endmodule

// File: tb/test_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module test_mc_ctrl_fsm;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] opcode;

  logic       iord, mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, alu_a_sel, reg_dst, mem_to_reg, reg_wr;
  logic [1:0] pc_src, alu_b_sel, alu_op;
  logic       t_iord, t_mem_rd, t_mem_wr, t_ir_wr, t_pc_wr, t_pc_wr_cond, t_alu_a_sel, t_reg_dst, t_mem_to_reg, t_reg_wr;
  logic [1:0] t_pc_src, t_alu_b_sel, t_alu_op;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mc_ctrl_fsm i_mc_ctrl_fsm (
    .clk(clk), .rst(rst), .opcode(opcode),
    .iord(iord), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .pc_wr(pc_wr),
    .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .alu_op(alu_op), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr)
  );

  mc_ctrl_fsm #(.TABLE_MODE(1'b1)) i_mc_ctrl_fsm_tbl (
    .clk(clk), .rst(rst), .opcode(opcode),
    .iord(t_iord), .mem_rd(t_mem_rd), .mem_wr(t_mem_wr), .ir_wr(t_ir_wr), .pc_wr(t_pc_wr),
    .pc_wr_cond(t_pc_wr_cond), .pc_src(t_pc_src), .alu_a_sel(t_alu_a_sel), .alu_b_sel(t_alu_b_sel),
    .alu_op(t_alu_op), .reg_dst(t_reg_dst), .mem_to_reg(t_mem_to_reg), .reg_wr(t_reg_wr)
  );

  wire [15:0] got = {iord, mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, pc_src,
                     alu_a_sel, alu_b_sel, alu_op, reg_dst, mem_to_reg, reg_wr};
  wire [15:0] got_tbl = {t_iord, t_mem_rd, t_mem_wr, t_ir_wr, t_pc_wr, t_pc_wr_cond, t_pc_src,
                         t_alu_a_sel, t_alu_b_sel, t_alu_op, t_reg_dst, t_mem_to_reg, t_reg_wr};

  // Bench-side encoding of one output word, written field by field.
  function automatic logic [15:0] mk(bit a_iord, bit a_rd, bit a_wr, bit a_ir, bit a_pc, bit a_pcc,
                                     logic [1:0] a_src, bit a_asel, logic [1:0] a_bsel,
                                     logic [1:0] a_op, bit a_dst, bit a_m2r, bit a_rw);
    return {a_iord, a_rd, a_wr, a_ir, a_pc, a_pcc, a_src, a_asel, a_bsel, a_op, a_dst, a_m2r, a_rw};
  endfunction

  function automatic logic [15:0] w_fetch();
    return mk(0, 1, 0, 1, 1, 0, 2'b00, 0, 2'b01, 2'b00, 0, 0, 0);
  endfunction

  function automatic int instr_len(logic [5:0] op);
    case (op)
      6'h23:        return 5;
      6'h2B, 6'h00: return 4;
      6'h04, 6'h02: return 3;
      default:      return 2;
    endcase
  endfunction

  function automatic logic [15:0] exp_word(logic [5:0] op, int k);
    if (k == 0) return w_fetch();
    if (k == 1) return mk(0, 0, 0, 0, 0, 0, 2'b00, 0, 2'b11, 2'b00, 0, 0, 0);
    case (op)
      6'h23: case (k)
        2:       return mk(0, 0, 0, 0, 0, 0, 2'b00, 1, 2'b10, 2'b00, 0, 0, 0);
        3:       return mk(1, 1, 0, 0, 0, 0, 2'b00, 0, 2'b00, 2'b00, 0, 0, 0);
        default: return mk(0, 0, 0, 0, 0, 0, 2'b00, 0, 2'b00, 2'b00, 0, 1, 1);
      endcase
      6'h2B: if (k == 2) return mk(0, 0, 0, 0, 0, 0, 2'b00, 1, 2'b10, 2'b00, 0, 0, 0);
             else        return mk(1, 0, 1, 0, 0, 0, 2'b00, 0, 2'b00, 2'b00, 0, 0, 0);
      6'h00: if (k == 2) return mk(0, 0, 0, 0, 0, 0, 2'b00, 1, 2'b00, 2'b10, 0, 0, 0);
             else        return mk(0, 0, 0, 0, 0, 0, 2'b00, 0, 2'b00, 2'b00, 1, 0, 1);
      6'h04: return mk(0, 0, 0, 0, 0, 1, 2'b01, 1, 2'b00, 2'b01, 0, 0, 0);
      default: return mk(0, 0, 0, 0, 1, 0, 2'b10, 0, 2'b00, 2'b00, 0, 0, 0);
    endcase
  endfunction

  function automatic string req_of(logic [5:0] op, int k);
    if (k == 0) return "R2";
    if (k == 1) return "R3";
    case (op)
      6'h23:   return "R4";
      6'h2B:   return "R5";
      6'h00:   return "R6";
      6'h04:   return "R7";
      6'h02:   return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] actual, logic [15:0] expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, actual, expected, $time);
    end
  endtask

  // Runs one instruction starting in its fetch cycle, just after a falling edge.
  // The opcode is valid only in decode; every other cycle carries junk (R9).
  task automatic run_instr(logic [5:0] op, int stop_after);
    int n;
    n = instr_len(op);
    if (stop_after > 0 && stop_after < n) n = stop_after;
    for (int k = 0; k < n; k++) begin
      opcode = (k == 1) ? op : 6'($urandom);
      #1;
      check(k >= 2 ? {req_of(op, k), "/R9"} : req_of(op, k), got, exp_word(op, k));
      check("R12", got_tbl, got);
      @(negedge clk);
    end
  endtask

  function automatic logic [5:0] pick_op(int unsigned u);
    case (u % 7)
      0:       return 6'h23;
      1:       return 6'h2B;
      2:       return 6'h00;
      3:       return 6'h04;
      4:       return 6'h02;
      5:       return 6'h3F;
      default: return 6'h11;
    endcase
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    rst    = 1'b1;
    opcode = 6'h23;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1", got, w_fetch());
    check("R12", got_tbl, got);
    rst = 1'b0;

    // Directed pass over every class, including two illegal opcodes (R10).
    run_instr(6'h23, 0);
    run_instr(6'h2B, 0);
    run_instr(6'h00, 0);
    run_instr(6'h04, 0);
    run_instr(6'h02, 0);
    run_instr(6'h3F, 0);
    run_instr(6'h22, 0);
    run_instr(6'h23, 0);

    // Reset cuts a load short after its memory-read state (R1).
    run_instr(6'h23, 4);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check("R1", got, w_fetch());
    check("R1", got_tbl, w_fetch());
    rst = 1'b0;
    run_instr(6'h2B, 0);

    // Random instruction stream.
    for (int i = 0; i < 300; i++) run_instr(pick_op($urandom), 0);

    // Final fetch confirms the last instruction length.
    opcode = 6'h00;
    #1;
    check("R2", got, w_fetch());
    summary();
  end

endmodule